// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This block produces the system reset for a processor subsystem. It runs from the system clock and a one-cycle enable pulse that arrives once every millisecond. Three conditions drive the reset. The first is a supply-good flag from an external comparator that goes low. The second is an active-low push-button held low long enough to pass debounce. The third is a watchdog that expires because the processor stopped toggling its strobe line. Whatever the cause, the reset is held for a fixed number of milliseconds after the cause goes away, so that supplies and clocks can settle.

The watchdog cannot be turned off. It counts milliseconds whenever reset is inactive. Only a high-to-low edge on the strobe restarts it, and strobe activity during reset is discarded. Every asynchronous input passes through a two-flop synchronizer. The reset leaves the block on two complementary lines.

Top module: `supervisor_wdt`

## Requirements
- R1: `period_sel` chooses the watchdog period: 2'b00 gives WD_P0_MS (150), 2'b01 gives WD_P1_MS (610), and 2'b10 or 2'b11 give WD_P2_MS (1200) milliseconds.
- R2: The watchdog count restarts only on a synchronized high-to-low edge of `strobe_n`. A strobe held low does not keep restarting it.
- R3: If no valid edge arrives within the selected period of ticks, the reset asserts on the clock that follows the final tick. No input disables this.
- R4: Strobe edges seen while reset is asserted have no effect on the watchdog.
- R5: `button_n` causes a reset only after its synchronized value has been low for DEBOUNCE_MS consecutive ticks. Shorter low pulses leave the reset deasserted.
- R6: Reset is asserted while `rst_n` is low, at power-up, and whenever the synchronized `supply_ok` is low.
- R7: The reset deasserts only after HOLD_MS ticks in which no cause is present. For the push-button, that count starts when the button returns high.
- R8: The watchdog starts from zero when reset deasserts, so the full selected period is always available after release.
- R9: `sys_reset` and `sys_reset_n` are always complementary.
- R10: `supply_ok`, `button_n` and `strobe_n` each pass through two flops. A supply drop appears on the reset outputs three clocks after it is sampled, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_ms | input | 1 | One-cycle millisecond enable |
| supply_ok | input | 1 | Supply within tolerance, from an external comparator |
| button_n | input | 1 | Manual reset push-button, active low |
| strobe_n | input | 1 | Watchdog strobe; falling edges restart the watchdog |
| period_sel | input | 2 | Watchdog period select |
| sys_reset | output | 1 | System reset, active high |
| sys_reset_n | output | 1 | System reset, active low |

## Verification
The bench builds the block with small tick counts: periods of 6, 11 and 17 ticks, a hold of 5 ticks and a debounce of 3 ticks, with a tick every fourth clock. At these values all four select codes, watchdog expiry, button presses just below and just above the debounce length, and supply drops can be driven to completion many times within a short run. A behavioural model compares both reset lines on every clock. Timing checks on release and expiry confirm the tick windows independently of that model.

// File: rtl/supervisor_wdt.sv
module supervisor_wdt #(
  parameter int WD_P0_MS    = 150,
  parameter int WD_P1_MS    = 610,
  parameter int WD_P2_MS    = 1200,
  parameter int HOLD_MS     = 250,
  parameter int DEBOUNCE_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       supply_ok,
  input  logic       button_n,
  input  logic       strobe_n,
  input  logic [1:0] period_sel,
  output logic       sys_reset,
  output logic       sys_reset_n
);

  localparam int MAXV = (WD_P2_MS > HOLD_MS) ?
                        ((WD_P2_MS > DEBOUNCE_MS) ? WD_P2_MS : DEBOUNCE_MS) :
                        ((HOLD_MS > DEBOUNCE_MS) ? HOLD_MS : DEBOUNCE_MS);
  localparam int W = $clog2(MAXV + 1);
  localparam logic [W-1:0] P0   = W'(WD_P0_MS);
  localparam logic [W-1:0] P1   = W'(WD_P1_MS);
  localparam logic [W-1:0] P2   = W'(WD_P2_MS);
  localparam logic [W-1:0] HOLD = W'(HOLD_MS);
  localparam logic [W-1:0] DEB  = W'(DEBOUNCE_MS);

  logic [2:0]   st_q;
  logic [1:0]   sup_q, btn_q;
  logic [W-1:0] btn_cnt, wd_cnt, hold_cnt, per;
  logic         rst_q, st_fall, btn_act, wd_hit, cause;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q  <= 3'b111;
      sup_q <= 2'b00;
      btn_q <= 2'b11;
    end else begin
      st_q  <= {st_q[1:0], strobe_n};
      sup_q <= {sup_q[0], supply_ok};
      btn_q <= {btn_q[0], button_n};
    end

  assign st_fall = st_q[2] & ~st_q[1];

  always_comb
    case (period_sel)
      2'b00:   per = P0;
      2'b01:   per = P1;
      default: per = P2;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          btn_cnt <= '0;
    else if (btn_q[1])                   btn_cnt <= '0;
    else if (tick_ms && btn_cnt != DEB)  btn_cnt <= btn_cnt + 1'b1;

  assign btn_act = ~btn_q[1] & (btn_cnt == DEB);

  assign wd_hit = ~rst_q & tick_ms & ~st_fall & (wd_cnt == per - 1'b1);
  assign cause  = ~sup_q[1] | btn_act | wd_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                wd_cnt <= '0;
    else if (rst_q || st_fall) wd_cnt <= '0;
    else if (tick_ms)          wd_cnt <= wd_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (cause) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_q && tick_ms) begin
      if (hold_cnt == HOLD - 1'b1) begin
        rst_q    <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end

  assign sys_reset   = rst_q;
  assign sys_reset_n = ~rst_q;

  p_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_q && tick_ms && !st_fall && wd_cnt == per - 1'b1) |=> rst_q);

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_q && st_fall) |=> (wd_cnt == '0));

  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> (wd_cnt == '0));

  p_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_q[1] |=> rst_q);

  p_button_r5: assert property (@(posedge clk) disable iff (!rst_n)
    btn_act |=> rst_q);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> ($past(tick_ms) && !$past(cause) && $past(hold_cnt) == HOLD - 1'b1));

  p_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> (wd_cnt == '0));

  p_never_above_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |-> (wd_cnt < per));

endmodule

// File: tb/sim_supervisor_wdt.sv
module sim_supervisor_wdt;
  localparam int CLK_NS = 10;
  localparam int TDIV   = 4;
  localparam int P0 = 6, P1 = 11, P2 = 17, HOLD = 5, DEB = 3;
  localparam int WATCHDOG_CYC = 20000;

  logic clk = 0, rst_n = 0, tick_ms = 0, supply_ok = 0, button_n = 1, strobe_n = 1;
  logic [1:0] period_sel = 2'b00;
  logic sys_reset, sys_reset_n;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R6";
  bit done = 0;

  supervisor_wdt #(.WD_P0_MS(P0), .WD_P1_MS(P1), .WD_P2_MS(P2),
                   .HOLD_MS(HOLD), .DEBOUNCE_MS(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .supply_ok(supply_ok),
    .button_n(button_n), .strobe_n(strobe_n), .period_sel(period_sel),
    .sys_reset(sys_reset), .sys_reset_n(sys_reset_n));

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference model
  int st_h[3], sup_h[2], btn_h[2];
  int m_bc = 0, m_wd = 0, m_hold = 0, m_per;
  bit m_rst = 1;
  initial begin
    st_h = '{1, 1, 1}; sup_h = '{0, 0}; btn_h = '{1, 1};
  end

  always @(posedge clk) begin
    bit fall, bact, hit, cause;
    if (!rst_n) begin
      st_h = '{1, 1, 1}; sup_h = '{0, 0}; btn_h = '{1, 1};
      m_bc = 0; m_wd = 0; m_hold = 0; m_rst = 1;
    end else begin
      fall  = (st_h[2] == 1) && (st_h[1] == 0);
      m_per = (period_sel == 2'b00) ? P0 : (period_sel == 2'b01) ? P1 : P2;
      bact  = (btn_h[1] == 0) && (m_bc == DEB);
      hit   = !m_rst && tick_ms && !fall && (m_wd + 1 == m_per);
      cause = (sup_h[1] == 0) || bact || hit;
      if (m_rst || fall) m_wd = 0; else if (tick_ms) m_wd++;
      if (btn_h[1] == 1) m_bc = 0; else if (tick_ms && m_bc < DEB) m_bc++;
      if (cause) begin m_rst = 1; m_hold = 0; end
      else if (m_rst && tick_ms) begin
        m_hold++;
        if (m_hold == HOLD) begin m_rst = 0; m_hold = 0; end
      end
      st_h[2] = st_h[1]; st_h[1] = st_h[0]; st_h[0] = strobe_n;
      sup_h[1] = sup_h[0]; sup_h[0] = supply_ok;
      btn_h[1] = btn_h[0]; btn_h[0] = button_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick_ms <= ((cyc % TDIV) == 0);
    if (!done) begin
      chk(sys_reset == m_rst, cur_req, sys_reset, m_rst);
      chk(sys_reset_n == !sys_reset, "R9", sys_reset_n, !sys_reset);
    end
    if (cyc > WATCHDOG_CYC && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_for(input bit val, input int limit, output int n);
    n = 0;
    while (sys_reset !== val && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_strobe();
    strobe_n = 0; wait_cyc(3); strobe_n = 1; wait_cyc(3);
  endtask

  initial begin
    int n;
    wait_cyc(4);
    chk(sys_reset == 1 && sys_reset_n == 0, "R6", sys_reset, 1);
    rst_n = 1;
    wait_cyc(20);
    chk(sys_reset == 1, "R6", sys_reset, 1);

    cur_req = "R7";
    supply_ok = 1;
    wait_for(0, 200, n);
    chk(n >= (HOLD - 1) * TDIV + 3 && n <= HOLD * TDIV + 4, "R7", n, HOLD * TDIV);

    cur_req = "R2";
    for (int k = 0; k < 10; k++) begin pulse_strobe(); wait_cyc(2 * TDIV); end
    chk(sys_reset == 0, "R2", sys_reset, 0);

    strobe_n = 0;
    wait_for(1, 200, n);
    chk(n >= (P0 - 1) * TDIV && n <= P0 * TDIV + 4, "R2", n, P0 * TDIV);
    strobe_n = 1;

    cur_req = "R4";
    wait_cyc(TDIV);
    for (int k = 0; k < 3; k++) pulse_strobe();
    wait_for(0, 200, n);
    wait_for(1, 200, n);
    chk(n >= (P0 - 1) * TDIV && n <= P0 * TDIV + 1, "R4", n, P0 * TDIV);

    cur_req = "R1";
    for (int s = 1; s < 4; s++) begin
      int exp_p;
      period_sel = 2'(s);
      exp_p = (s == 1) ? P1 : P2;
      wait_for(0, 200, n);
      wait_for(1, 400, n);
      chk(n >= (exp_p - 1) * TDIV && n <= exp_p * TDIV + 1, "R1", n, exp_p * TDIV);
      chk(n >= (exp_p - 1) * TDIV, "R8", n, exp_p * TDIV);
    end

    cur_req = "R5";
    period_sel = 2'b10;
    wait_for(0, 200, n);
    pulse_strobe();
    button_n = 0; wait_cyc(2 * TDIV - 1); button_n = 1;
    wait_cyc(6);
    chk(sys_reset == 0, "R5", sys_reset, 0);
    pulse_strobe();
    button_n = 0; wait_cyc(DEB * TDIV + 3 * TDIV);
    chk(sys_reset == 1, "R5", sys_reset, 1);
    wait_cyc(2 * TDIV);
    cur_req = "R7";
    button_n = 1;
    wait_cyc((HOLD - 1) * TDIV);
    chk(sys_reset == 1, "R7", sys_reset, 1);
    wait_for(0, 200, n);
    chk(n <= 2 * TDIV + 4, "R7", n, TDIV);

    cur_req = "R10";
    pulse_strobe();
    supply_ok = 0;
    wait_cyc(2);
    chk(sys_reset == 0, "R10", sys_reset, 0);
    wait_cyc(1);
    chk(sys_reset == 1, "R10", sys_reset, 1);
    cur_req = "R6";
    wait_cyc(10 * TDIV);
    chk(sys_reset == 1, "R6", sys_reset, 1);
    supply_ok = 1;
    wait_for(0, 200, n);
    chk(sys_reset == 0, "R6", sys_reset, 0);

    cur_req = "R3";
    wait_for(1, 400, n);
    chk(n >= (P2 - 1) * TDIV && n <= P2 * TDIV + 1, "R3", n, P2 * TDIV);
    wait_cyc(5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule